// File: doc/BRIEF.md
# Windowed Watchdog Timer

A watchdog with a down counter that is clocked by a slow tick enable. Software arms it by writing one mode register a single time. After that it must restart the counter through the control register, and only inside a window. The counter has to have fallen to or below a programmable delta before a restart is accepted. There are two fault causes:

- the counter runs out;
- software restarts it too early.

Either fault sets a flag in the status register. Depending on the mode bits, the fault also produces a one-cycle reset pulse, aimed at the whole system or at the processor alone, and/or a level interrupt that holds until software reads the status.

The block sits on a simple word-addressed register bus. Word 0 is the control register, word 1 the mode register and word 2 the status register. Two halt inputs can freeze the counter while a debugger holds the core or the core is idle, provided the matching mode bit allows it.

Top module: `wdog_window`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF. The status register reads 0, and irq_o, sys_rst_o and cpu_rst_o are low.
- R2: The mode register is at word 1 and has this layout:
  - [11:0] reload value;
  - [27:16] window delta;
  - bit 12 interrupt enable;
  - bit 13 reset enable;
  - bit 14 processor-only reset;
  - bit 15 disable;
  - bit 28 debug-halt enable;
  - bit 29 idle-halt enable.

  Bits [31:30] read as 0. A write also loads the counter with the new reload value.
- R3: The first mode write after reset locks the register. Later mode writes leave it unchanged.
- R4: Each tick_en cycle decrements the counter. A tick while the counter is 0 is an underflow fault and reloads the counter. With reset enable set, a fault gives a reset pulse exactly one cycle wide.
- R5: A restart is a write to word 0 with 0xA5 in bits [31:24] and bit 0 set. A restart while the counter is above the delta is an error fault and does not reload the counter.
- R6: A restart while the counter is at or below the delta reloads the counter and raises no fault.
- R7: A control write with any other key is ignored: no reload and no fault.
- R8: The status register is at word 2. Bit 0 flags an underflow and bit 1 flags an error. A read returns the flags and clears them.
- R9: When debug-halt enable is set and dbg_halt is high, ticks do not move the counter. idle_halt has no effect while idle-halt enable is clear.
- R10: With interrupt enable set, a fault drives irq_o high. irq_o stays high until the status register is read.
- R11: With processor-only reset set, a fault pulses cpu_rst_o instead of sys_rst_o. The two are never high together.
- R12: With disable set, the counter stops and no fault, flag or output is ever produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| tick_en | input | 1 | Slow-clock tick enable, one cycle per count |
| dbg_halt | input | 1 | Debug halt request |
| idle_halt | input | 1 | Idle halt request |
| irq_o | output | 1 | Fault interrupt, level |
| sys_rst_o | output | 1 | System reset pulse |
| cpu_rst_o | output | 1 | Processor reset pulse |

## Verification
The one-cycle pulse property assumes that two faults never land on consecutive clock cycles. An underflow tick directly followed by an early restart would break that assumption. The stimulus keeps at least one idle cycle between ticks and between bus accesses. The disable property assumes a fault already in the two-stage pipeline has drained before the register goes disabled. Every scenario therefore starts from a fresh reset, and its first mode write happens before any tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_MODE  = 1;
  localparam int ADDR_STAT  = 2;
  localparam int B_FIEN     = 12;
  localparam int B_RSTEN    = 13;
  localparam int B_RPROC    = 14;
  localparam int B_DIS      = 15;
  localparam int B_DBGH     = 28;
  localparam int B_IDLH     = 29;
  localparam int DELTA_LSB  = 16;
  localparam logic [31:0] MODE_RST  = 32'h3FFF2FFF;
  localparam logic [31:0] MODE_MASK = 32'h3FFFFFFF;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       mode_q,
  output logic              locked_q,
  output logic              mode_load,
  output logic              restart
);
  logic wr_mode, wr_ctrl;

  always_comb begin
    wr_mode   = bus_wr && (bus_addr == ADDR_W'(ADDR_MODE));
    wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    mode_load = wr_mode && !locked_q;
    restart   = wr_ctrl && (bus_wdata[31:24] == KEY) && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_load) begin
      mode_q   <= bus_wdata & MODE_MASK;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             disabled,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] delta,
  input  logic             mode_load,
  input  logic [CNT_W-1:0] new_reload,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf_q,
  output logic             err_q
);
  logic run;
  assign run = !disabled && !freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
      if (mode_load) begin
        cnt_q <= new_reload;
      end else if (restart && !disabled) begin
        if (cnt_q > delta) err_q <= 1'b1;
        else               cnt_q <= reload;
      end else if (tick_en && run) begin
        if (cnt_q == '0) begin
          uf_q  <= 1'b1;
          cnt_q <= reload;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault (
  input  logic       clk,
  input  logic       rst,
  input  logic       uf,
  input  logic       err,
  input  logic       fien,
  input  logic       rsten,
  input  logic       rproc,
  input  logic       stat_rd,
  output logic [1:0] status_q,
  output logic       irq_q,
  output logic       sys_rst_q,
  output logic       cpu_rst_q
);
  logic fault;
  assign fault = uf | err;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      irq_q     <= 1'b0;
      sys_rst_q <= 1'b0;
      cpu_rst_q <= 1'b0;
    end else begin
      status_q  <= (stat_rd ? 2'b00 : status_q) | {err, uf};
      irq_q     <= (fault && fien) || (irq_q && !stat_rd);
      sys_rst_q <= fault && rsten && !rproc;
      cpu_rst_q <= fault && rsten && rproc;
    end
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ADDR_W = 2,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  input  logic              dbg_halt,
  input  logic              idle_halt,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              cpu_rst_o
);
  logic [31:0]      mode_q;
  logic             mode_locked, mode_load, restart;
  logic [CNT_W-1:0] cnt;
  logic             uf, err, freeze, stat_rd;
  logic [1:0]       status;

  wdog_regs #(.ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_q(mode_q), .locked_q(mode_locked),
    .mode_load(mode_load), .restart(restart)
  );

  assign freeze = (mode_q[B_DBGH] && dbg_halt) || (mode_q[B_IDLH] && idle_halt);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .freeze(freeze),
    .disabled(mode_q[B_DIS]), .reload(mode_q[CNT_W-1:0]),
    .delta(mode_q[DELTA_LSB +: CNT_W]), .mode_load(mode_load),
    .new_reload(bus_wdata[CNT_W-1:0]), .restart(restart),
    .cnt_q(cnt), .uf_q(uf), .err_q(err)
  );

  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_STAT));

  wdog_fault u_fault (
    .clk(clk), .rst(rst), .uf(uf), .err(err),
    .fien(mode_q[B_FIEN]), .rsten(mode_q[B_RSTEN]), .rproc(mode_q[B_RPROC]),
    .stat_rd(stat_rd), .status_q(status), .irq_q(irq_o),
    .sys_rst_q(sys_rst_o), .cpu_rst_q(cpu_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(ADDR_MODE): bus_rdata <= mode_q;
        ADDR_W'(ADDR_STAT): bus_rdata <= {30'b0, status};
        default:            bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      mode_q,
  input logic             mode_locked,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_o,
  input logic             sys_rst_o,
  input logic             cpu_rst_o
);
  a_r3_write_once: assert property (@(posedge clk) disable iff (rst)
    mode_locked |=> $stable(mode_q));

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_o || cpu_rst_o) |=> !(sys_rst_o || cpu_rst_o));

  a_r6_cnt_within_reload: assert property (@(posedge clk) disable iff (rst)
    cnt <= mode_q[CNT_W-1:0]);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(mode_q[12]));

  a_r11_reset_kinds_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_o && cpu_rst_o));

  a_r12_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    (mode_q[15] && $past(mode_q[15]) && $past(mode_q[15], 2))
      |-> !(sys_rst_o || cpu_rst_o || $rose(irq_o)));
endmodule

bind wdog_window wdog_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .mode_locked(mode_locked),
  .cnt(cnt), .irq_o(irq_o), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
);

// File: tb/test_wdog_window.sv
`timescale 1ns/1ps
module test_wdog_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0, dbg_halt = 1'b0, idle_halt = 1'b0;
  logic        irq_o, sys_rst_o, cpu_rst_o;
  int          n_chk = 0, n_bad = 0;
  int          sys_cnt = 0, cpu_cnt = 0;

  always #2.5 clk = ~clk;

  wdog_window i_wdog_window (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .dbg_halt(dbg_halt), .idle_halt(idle_halt),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
  );

  always @(negedge clk) begin
    if (sys_rst_o) sys_cnt++;
    if (cpu_rst_o) cpu_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    rd(2'd1, d); check("R1 mode reset", d, 32'h3FFF2FFF);
    rd(2'd2, d); check("R1 status reset", d, 0);
    check("R1 outputs idle", {29'b0, irq_o, sys_rst_o, cpu_rst_o}, 0);
  endtask

  task automatic t_lock_and_faults();
    logic [31:0] d;
    int s0;
    do_reset();
    wr(2'd1, 32'hC003_2005);
    rd(2'd1, d); check("R2 mode layout", d, 32'h0003_2005);
    wr(2'd1, 32'h00FF_3001);
    rd(2'd1, d); check("R3 write once", d, 32'h0003_2005);
    s0 = sys_cnt;
    ticks(5); check("R4 no fault before zero", sys_cnt - s0, 0);
    ticks(1); check("R4 underflow single pulse", sys_cnt - s0, 1);
    check("R11 no cpu pulse", cpu_cnt, 0);
    rd(2'd2, d); check("R8 underflow flag", d, 1);
    rd(2'd2, d); check("R8 read clears", d, 0);
    s0 = sys_cnt;
    wr(2'd0, 32'hA500_0001);
    check("R5 early restart pulse", sys_cnt - s0, 1);
    rd(2'd2, d); check("R5 error flag", d, 2);
    ticks(2);
    s0 = sys_cnt;
    wr(2'd0, 32'hA500_0001);
    check("R6 legal restart no fault", sys_cnt - s0, 0);
    ticks(5); check("R6 reloaded count", sys_cnt - s0, 0);
    ticks(1); check("R6 underflow after reload", sys_cnt - s0, 1);
    rd(2'd2, d);
    s0 = sys_cnt;
    ticks(4);
    wr(2'd0, 32'h5A00_0001);
    check("R7 bad key no fault", sys_cnt - s0, 0);
    ticks(1); check("R7 bad key no reload a", sys_cnt - s0, 0);
    ticks(1); check("R7 bad key no reload b", sys_cnt - s0, 1);
    rd(2'd2, d); check("R7 only underflow flag", d, 1);
  endtask

  task automatic t_halt();
    int s0;
    do_reset();
    wr(2'd1, 32'h1FFF_2002);
    dbg_halt = 1'b1; idle_halt = 1'b1;
    s0 = sys_cnt;
    ticks(10); check("R9 frozen by debug halt", sys_cnt - s0, 0);
    dbg_halt = 1'b0;
    ticks(2); check("R9 idle halt not enabled counts", sys_cnt - s0, 0);
    ticks(1); check("R9 resumes to underflow", sys_cnt - s0, 1);
    idle_halt = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    int s0, c0;
    do_reset();
    wr(2'd1, 32'h0000_1001);
    s0 = sys_cnt; c0 = cpu_cnt;
    ticks(2);
    check("R10 irq raised", {31'b0, irq_o}, 1);
    check("R10 no reset pulse", (sys_cnt - s0) + (cpu_cnt - c0), 0);
    repeat (6) @(negedge clk);
    check("R10 irq held", {31'b0, irq_o}, 1);
    rd(2'd2, d);
    @(negedge clk);
    check("R10 irq cleared by read", {31'b0, irq_o}, 0);
  endtask

  task automatic t_proc();
    int s0, c0;
    do_reset();
    wr(2'd1, 32'h0000_6001);
    s0 = sys_cnt; c0 = cpu_cnt;
    ticks(2);
    check("R11 cpu pulse", cpu_cnt - c0, 1);
    check("R11 no sys pulse", sys_cnt - s0, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int s0;
    do_reset();
    wr(2'd1, 32'h0000_A001);
    s0 = sys_cnt;
    ticks(5);
    wr(2'd0, 32'hA500_0001);
    check("R12 disabled no pulse", sys_cnt - s0, 0);
    rd(2'd2, d); check("R12 disabled no flags", d, 0);
    check("R12 disabled no irq", {31'b0, irq_o}, 0);
  endtask

  initial begin
    t_reset_state();
    t_lock_and_faults();
    t_halt();
    t_irq();
    t_proc();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule